// File: doc/BRIEF.md
# Serial Transceiver Core with Internal Loopback

This block is an 8N1 asynchronous serial transmitter and receiver pair. Each direction has a 16-entry FIFO. Software-side logic pushes bytes into the transmit FIFO through a byte-wide write port. Received words are popped from a show-ahead read port, which shows the byte together with a break indication. A simple integer divider produces a tick at sixteen times the bit rate. The transmitter uses that tick to time each bit. The receiver uses it to find the start edge and to sample each bit at its middle.

A loopback control moves the receiver's input from the external receive pin to the block's own outgoing serial line. The loop is closed at the bit level, after the transmit FIFO and the serializer. Looped bytes therefore drain at the real frame rate and are reassembled by the receiver. While loopback is on, the transmit line, including any break the caller requests, is still driven to the output pin. Everything on the external receive pin is cut off in this mode, including its break detection.

A break request input holds the outgoing line low. A receiver that sees the line stay low through the stop-bit position, with all data bits zero, stores one break word: data 0x00 with the break flag set. It then waits for the line to return high. If a frame completes while the receive FIFO is full, the frame is dropped and a sticky overrun flag is raised. The data already stored is kept.

Top module: `uart_lb_core`

## Requirements
- R1: The transmit pin idles high. Each byte is sent as one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts 16*DIV clocks.
- R2: With loopback off, a well-formed frame on the external receive pin is delivered on the read port with its byte value and the break flag at 0, in arrival order.
- R3: With loopback on, every byte written to the transmit FIFO is reassembled by the receiver and delivered on the read port in write order with the break flag at 0.
- R4: With loopback on, transmitted frames still appear on the transmit pin in full.
- R5: With loopback on, frames and breaks on the external receive pin add nothing to the receive FIFO.
- R6: While the break request is high, the transmit pin is low. With loopback on, one break is held and released to give exactly one break word: data 0x00, flag 1.
- R7: With loopback off, holding the external receive pin low for longer than a frame gives exactly one break word: data 0x00, flag 1.
- R8: The transmit FIFO holds 16 bytes. tx_full rises once 16 bytes are waiting. A write while full is ignored, and no frame is ever sent for it.
- R9: A frame that completes while the receive FIFO holds 16 words is dropped. rx_overrun is then set and stays set until reset, and the 16 stored words read back unchanged.
- R10: The read port pops only when rx_rd_en is high and rx_empty is low. rx_empty is high exactly when no word is waiting.
- R11: After reset, txd is 1, tx_empty and rx_empty are 1, and tx_full, rx_full and rx_overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Push tx_wr_data into the transmit FIFO |
| tx_wr_data | input | 8 | Byte to transmit |
| rx_rd_en | input | 1 | Pop the word shown on the read port |
| rx_rd_data | output | 8 | Byte at the head of the receive FIFO |
| rx_rd_brk | output | 1 | Break flag of the head word |
| brk_req | input | 1 | Hold the outgoing serial line low |
| lpbk_en | input | 1 | Feed the receiver from the outgoing line instead of rxd |
| rxd | input | 1 | External serial input |
| txd | output | 1 | External serial output |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_overrun | output | 1 | Sticky flag: a frame was lost to a full receive FIFO |

## Verification
Some properties are checked on every cycle. A full FIFO stays full without a pop, and an empty one stays empty without a push. The serializer always leaves a frame on a high stop bit. A stored break word always carries zero data. The overrun flag never clears on its own. The bench scenarios cover what needs whole frames to show:
- correct bit timing and order on the pin;
- the loop delivering bytes while the pin keeps toggling;
- the external pin, frames and breaks alike, being cut off during loopback;
- one break word per held break;
- the ignored seventeenth write;
- the lost frame that follows a full receive FIFO.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    localparam logic [3:0] SUB_MID  = 4'd7;
    localparam logic [3:0] SUB_LAST = 4'd15;
    localparam logic [3:0] BIT_STOP = 4'd9;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_RUN,
        RX_WAIT_HI
    } rx_state_e;
endpackage

// File: rtl/uart_lb_tick.sv
module uart_lb_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/uart_lb_fifo.sv
module uart_lb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty_o = (st_q.wp == st_q.rp);
    assign full_o  = (st_q.wp[AW] != st_q.rp[AW]) &&
                     (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[st_q.rp[AW-1:0]];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp[AW-1:0]] <= push_data_i;
    end

    // R8: a full queue stays full unless something is taken out
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i) |=> full_o);
    // R10: an empty queue stays empty unless something is put in
    a_r10_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_lb_tx.sv
module uart_lb_tx
    import uart_lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       fifo_empty_i,
    input  logic [7:0] fifo_data_i,
    output logic       pop_o,
    output logic       line_o
);
    typedef struct packed {
        logic       busy;
        logic [9:0] sh;
        logic [3:0] sub;
        logic [3:0] bitn;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pop_o = 1'b0;
        if (!st_q.busy) begin
            if (!fifo_empty_i) begin
                st_d.busy = 1'b1;
                st_d.sh   = {1'b1, fifo_data_i, 1'b0};
                st_d.sub  = '0;
                st_d.bitn = '0;
                pop_o     = 1'b1;
            end
        end else if (tick_i) begin
            if (st_q.sub == SUB_LAST) begin
                st_d.sub = '0;
                st_d.sh  = {1'b1, st_q.sh[9:1]};
                if (st_q.bitn == BIT_STOP) st_d.busy = 1'b0;
                else                       st_d.bitn = st_q.bitn + 4'd1;
            end else begin
                st_d.sub = st_q.sub + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, sh: '1, sub: '0, bitn: '0};
        else        st_q <= st_d;
    end

    assign line_o = st_q.busy ? st_q.sh[0] : 1'b1;

    // R1: every frame ends on a high stop bit
    a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(line_o));
endmodule

// File: rtl/uart_lb_rx.sv
module uart_lb_rx
    import uart_lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       line_i,
    output logic       push_o,
    output logic [7:0] data_o,
    output logic       brk_o
);
    typedef struct packed {
        rx_state_e  st;
        logic [7:0] sh;
        logic [3:0] sub;
        logic [3:0] bitn;
        logic       seen_hi;
        logic       push;
        logic [7:0] data;
        logic       brk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        unique case (st_q.st)
            RX_IDLE: begin
                if (tick_i && !line_i) begin
                    st_d.st      = RX_RUN;
                    st_d.sub     = '0;
                    st_d.bitn    = '0;
                    st_d.seen_hi = 1'b0;
                end
            end
            RX_RUN: begin
                if (tick_i) begin
                    if (st_q.sub == SUB_LAST) begin
                        st_d.sub  = '0;
                        st_d.bitn = st_q.bitn + 4'd1;
                    end else begin
                        st_d.sub = st_q.sub + 4'd1;
                    end
                    if (st_q.sub == SUB_MID) begin
                        if (st_q.bitn == 4'd0) begin
                            if (line_i) st_d.st = RX_IDLE;
                        end else if (st_q.bitn == BIT_STOP) begin
                            if (line_i) begin
                                st_d.push = 1'b1;
                                st_d.data = st_q.sh;
                                st_d.brk  = 1'b0;
                                st_d.st   = RX_IDLE;
                            end else begin
                                if (!st_q.seen_hi) begin
                                    st_d.push = 1'b1;
                                    st_d.data = '0;
                                    st_d.brk  = 1'b1;
                                end
                                st_d.st = RX_WAIT_HI;
                            end
                        end else begin
                            st_d.sh      = {line_i, st_q.sh[7:1]};
                            st_d.seen_hi = st_q.seen_hi | line_i;
                        end
                    end
                end
            end
            RX_WAIT_HI: begin
                if (line_i) st_d.st = RX_IDLE;
            end
            default: st_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: RX_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign push_o = st_q.push;
    assign data_o = st_q.data;
    assign brk_o  = st_q.brk;

    // R7: a stored break word carries zero data
    a_r7_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && brk_o) |-> (data_o == 8'h00));
endmodule

// File: rtl/uart_lb_core.sv
module uart_lb_core #(
    parameter int DIV   = 27,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_wr_en,
    input  logic [7:0] tx_wr_data,
    input  logic       rx_rd_en,
    output logic [7:0] rx_rd_data,
    output logic       rx_rd_brk,
    input  logic       brk_req,
    input  logic       lpbk_en,
    input  logic       rxd,
    output logic       txd,
    output logic       tx_empty,
    output logic       tx_full,
    output logic       rx_empty,
    output logic       rx_full,
    output logic       rx_overrun
);
    localparam int RXW = 9;

    typedef struct packed {
        logic [1:0] sync;
        logic       ovr;
    } st_t;

    st_t st_d, st_q;

    logic       tick;
    logic       tx_pop;
    logic [7:0] tx_head;
    logic       tx_line;
    logic       rx_src;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       rx_brk;
    logic [RXW-1:0] rx_head;

    uart_lb_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    uart_lb_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_wr_en), .push_data_i(tx_wr_data),
        .pop_i(tx_pop), .head_o(tx_head),
        .empty_o(tx_empty), .full_o(tx_full)
    );

    uart_lb_tx u_ser (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .fifo_empty_i(tx_empty), .fifo_data_i(tx_head),
        .pop_o(tx_pop), .line_o(tx_line)
    );

    assign txd    = tx_line & ~brk_req;
    assign rx_src = lpbk_en ? txd : rxd;

    uart_lb_rx u_des (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .line_i(st_q.sync[1]),
        .push_o(rx_push), .data_o(rx_data), .brk_o(rx_brk)
    );

    uart_lb_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_push), .push_data_i({rx_brk, rx_data}),
        .pop_i(rx_rd_en), .head_o(rx_head),
        .empty_o(rx_empty), .full_o(rx_full)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], rx_src};
        if (rx_push && rx_full) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sync: 2'b11, ovr: 1'b0};
        else        st_q <= st_d;
    end

    assign rx_rd_data = rx_head[7:0];
    assign rx_rd_brk  = rx_head[8];
    assign rx_overrun = st_q.ovr;

    // R9: the overrun flag is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);
endmodule

// File: tb/uart_lb_core_tb.sv
module uart_lb_core_tb;
    localparam int DIV = 4;
    localparam int BP  = 16 * DIV;
    localparam int FR  = 10 * BP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic       rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data;
    logic       rx_rd_brk;
    logic       brk_req = 1'b0;
    logic       lpbk_en = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, tx_empty, tx_full, rx_empty, rx_full, rx_overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [8:0] mon_q[$];   // {stop, data} decoded from txd
    logic [8:0] exp_q[$];   // {brk, data} expected on the read port

    always #4 clk = ~clk;

    uart_lb_core #(.DIV(DIV), .DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_rd_brk(rx_rd_brk),
        .brk_req(brk_req), .lpbk_en(lpbk_en), .rxd(rxd), .txd(txd),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ext(input logic [7:0] b);
        rxd = 1'b0; cyc(BP);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; cyc(BP); end
        rxd = 1'b1; cyc(BP);
    endtask

    task automatic ext_break(input int n);
        rxd = 1'b0; cyc(n); rxd = 1'b1; cyc(BP);
    endtask

    task automatic wr(input logic [7:0] b);
        tx_wr_en = 1'b1; tx_wr_data = b; cyc(1); tx_wr_en = 1'b0;
    endtask

    task automatic rd_expect(input string req);
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(!rx_empty, {req, " word present"}, rx_empty, 0);
        chk({rx_rd_brk, rx_rd_data} == e, req, {rx_rd_brk, rx_rd_data}, e);
        rx_rd_en = 1'b1; cyc(1); rx_rd_en = 1'b0; cyc(1);
    endtask

    // bench-side decoder of the txd pin
    initial begin
        logic [7:0] b;
        logic st;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                cyc(BP / 2);
                if (txd == 1'b0) begin
                    for (int i = 0; i < 8; i++) begin cyc(BP); b[i] = txd; end
                    cyc(BP); st = txd;
                    mon_q.push_back({st, b});
                    while (txd == 1'b0) @(negedge clk);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(2);
        // R11 reset state
        chk(txd == 1'b1, "R11 txd", txd, 1);
        chk(tx_empty && rx_empty, "R11 empties", {tx_empty, rx_empty}, 3);
        chk(!tx_full && !rx_full && !rx_overrun, "R11 full/ovr",
            {tx_full, rx_full, rx_overrun}, 0);

        // R2 external frames, loopback off
        send_ext(8'hA5); send_ext(8'h3C); send_ext(8'h01);
        exp_q.push_back({1'b0, 8'hA5});
        exp_q.push_back({1'b0, 8'h3C});
        exp_q.push_back({1'b0, 8'h01});
        cyc(BP);
        rd_expect("R2"); rd_expect("R2"); rd_expect("R2");
        // R10 pop on empty has no effect
        chk(rx_empty, "R10 empty after drain", rx_empty, 1);
        rx_rd_en = 1'b1; cyc(2); rx_rd_en = 1'b0; cyc(1);
        chk(rx_empty && !rx_full, "R10 pop on empty", {rx_empty, rx_full}, 2);

        // R1 transmit framing, loopback off: nothing received
        wr(8'h5A);
        cyc(FR + 2 * BP);
        chk(mon_q.size() == 1, "R1 frame count", mon_q.size(), 1);
        if (mon_q.size() > 0) begin
            logic [8:0] m;
            m = mon_q.pop_front();
            chk(m == {1'b1, 8'h5A}, "R1 frame bits", m, {1'b1, 8'h5A});
        end
        chk(rx_empty, "R1 no self receive without loopback", rx_empty, 1);

        // R3 R4 R5 loopback with external noise
        lpbk_en = 1'b1; cyc(4);
        fork
            begin send_ext(8'hFF); send_ext(8'h00); ext_break(12 * BP); end
            begin
                wr(8'h81); wr(8'h7E); wr(8'h00);
                exp_q.push_back({1'b0, 8'h81});
                exp_q.push_back({1'b0, 8'h7E});
                exp_q.push_back({1'b0, 8'h00});
            end
        join
        cyc(3 * FR);
        rd_expect("R3"); rd_expect("R3"); rd_expect("R3");
        chk(rx_empty, "R5 pin ignored in loopback", rx_empty, 1);
        chk(mon_q.size() == 3, "R4 frames on pin", mon_q.size(), 3);
        while (mon_q.size() > 0) begin
            logic [8:0] m;
            m = mon_q.pop_front();
            chk(m[8] == 1'b1, "R4 stop bit on pin", m[8], 1);
        end

        // R6 break request in loopback
        brk_req = 1'b1; cyc(4);
        chk(txd == 1'b0, "R6 txd low on break", txd, 0);
        cyc(12 * BP); brk_req = 1'b0; cyc(2 * BP);
        exp_q.push_back({1'b1, 8'h00});
        rd_expect("R6");
        chk(rx_empty, "R6 single break word", rx_empty, 1);
        chk(mon_q.size() == 1, "R6 break seen on pin", mon_q.size(), 1);
        mon_q.delete();

        // R7 external break, loopback off
        lpbk_en = 1'b0; cyc(4);
        ext_break(12 * BP); cyc(BP);
        exp_q.push_back({1'b1, 8'h00});
        rd_expect("R7");
        chk(rx_empty, "R7 single break word", rx_empty, 1);

        // R8 R9 fill and overflow, loopback on
        lpbk_en = 1'b1; cyc(4);
        tx_wr_en = 1'b1;
        for (int i = 0; i < 17; i++) begin tx_wr_data = 8'(i * 7 + 3); cyc(1); end
        tx_wr_en = 1'b0;
        chk(tx_full, "R8 tx full at 16 waiting", tx_full, 1);
        wr(8'hEE);
        cyc(19 * FR);
        chk(mon_q.size() == 17, "R8 ignored write not sent", mon_q.size(), 17);
        chk(rx_full, "R9 rx full", rx_full, 1);
        chk(rx_overrun, "R9 overrun set", rx_overrun, 1);
        for (int i = 0; i < 16; i++) exp_q.push_back({1'b0, 8'(i * 7 + 3)});
        for (int i = 0; i < 16; i++) rd_expect("R9");
        chk(rx_empty, "R9 lost frame not stored", rx_empty, 1);
        chk(rx_overrun, "R9 overrun sticky", rx_overrun, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule